// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a double-data-rate SDRAM: chip select, the row strobe, the column strobe, write enable, the two bank-select bits and the address bus. On every rising clock edge it turns them into one command. It checks that command against the current state of the bank it addresses, then updates a small state machine for each of the four banks. A bank is idle, holding an open row, running a read burst or running a write burst.

Each cycle, one clock after the edge that sampled the pins, the block reports three things: the decoded command, whether it was legal, and which action it caused. The possible actions are opening a row, starting a burst, cutting a burst short, precharging and refreshing. Two further outputs mark a mode-register load and an illegal command. An illegal command is reported together with its bank number and otherwise behaves like a NOP. The block also keeps the row latched in each bank, the column of the latest burst and the latest accepted mode-register value. A monitor in a memory controller, or a memory model, uses it to follow and police the command stream.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select low, the block decodes {row strobe, column strobe, write enable} as follows: 111 NOP, 110 burst terminate, 101 READ, 100 WRITE, 011 ACTIVATE, 010 PRECHARGE, 001 auto refresh, 000 mode-register load. With chip select high the command is DESELECT. The command is reported on `cmdCode` one clock after its sampling edge, coded as DESELECT 0, NOP 1, terminate 2, READ 3, WRITE 4, ACTIVATE 5, PRECHARGE 6, refresh 7, mode load 8.
- R2: DESELECT and NOP are always legal and cause no action. Any burst in progress keeps running to its end.
- R3: ACTIVATE is legal only when the addressed bank is idle. It latches the whole address bus as that bank's row and moves the bank to open. `bankStates` carries 2 bits per bank, with bank n at bits [2n+1:2n], coded as idle 0, open 1, read burst 2, write burst 3.
- R4: READ or WRITE to an open bank is legal. It latches address bits [9:0] as the burst column and puts the bank into state 2 or 3. The bank stays there for BL/2 cycles and then returns to open. BL is taken from mode-register bits [2:0]: code 1 gives BL 2, code 2 gives BL 4, code 3 gives BL 8, and any other code gives BL 2.
- R5: Address bit 10 set on a READ or WRITE requests auto-precharge. The bank then returns to idle, not open, when its burst ends. While such a burst runs, terminate, READ and WRITE to that bank are illegal.
- R6: A READ to a bank in a read burst without auto-precharge is legal. It reports both a burst stop and a burst start, latches the new column and restarts the burst length. A WRITE during a write burst behaves the same way. A READ during a write burst is illegal, and so is a WRITE during a read burst.
- R7: Burst terminate is legal only for a bank in a read burst without auto-precharge. It reports a stop and returns the bank to open.
- R8: PRECHARGE is always legal and reports a precharge. With address bit 10 low it idles the addressed bank. With bit 10 high it idles every bank. A stop is also reported when any bank it idles was bursting.
- R9: Auto refresh is legal only when all four banks are idle, and it reports a refresh.
- R10: A mode-register load is legal only when all banks are idle. It copies the address bus into `modeReg`. `modeReg` changes at no other time.
- R11: An illegal command pulses `illegalPulse` for one cycle, with its bank on `cmdBank`. It reports no action and changes no row, column, mode or bank state except the normal end of a running burst.
- R12: While reset is held, every bank is idle, `modeReg`, the latched rows and the column are zero, and `cmdCode` is 0 with no legal flag and no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address bus (row, column, bit 10 flag, mode value) |
| cmdCode | output | 4 | Decoded command of the previous edge |
| cmdLegal | output | 1 | That command was legal |
| illegalPulse | output | 1 | That command was illegal |
| cmdBank | output | 2 | Bank addressed by that command |
| actOpen | output | 1 | A row was opened |
| actBurst | output | 1 | A read or write burst started |
| actStop | output | 1 | A running burst was cut short |
| actPrecharge | output | 1 | One or all banks were precharged |
| actRefresh | output | 1 | An auto refresh was accepted |
| actModeLoad | output | 1 | The mode register was loaded |
| bankStates | output | 8 | Two-bit state per bank |
| autoPreFlags | output | 4 | Pending auto-precharge per bank |
| rowOfBank | output | 52 | Latched row per bank, 13 bits each, bank 0 lowest |
| burstCol | output | 10 | Column of the latest burst |
| modeReg | output | 13 | Last accepted mode-register value |

## Verification
The hardest case to reach from the ports is a command that arrives while a burst is still running with auto-precharge pending. By then the bank has to be opened, a long burst length loaded and the burst started, and the command must land inside the few cycles the burst lasts. The stimulus first loads burst length 8 so each burst lasts four cycles. It then issues terminate, a second WRITE and a READ on consecutive cycles inside such bursts, and checks that the bank still falls back to idle on the cycle the original count runs out. It also interrupts an unflagged read on the cycle after it starts, and precharges every bank while a write burst is live.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int SD_BANKS  = 4;
  localparam int SD_BANK_W = $clog2(SD_BANKS);
  localparam int SD_CNT_W  = 2;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_TERM  = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_RD   = 2'd2,
    BK_WR   = 2'd3
  } bank_e;

  // strobes from the control to the bank datapath, already gated by legality
  typedef struct packed {
    logic                 openRow;
    logic                 startRd;
    logic                 startWr;
    logic                 termBurst;
    logic                 preOne;
    logic                 preAll;
    logic                 loadMode;
    logic                 autoPre;
    logic [SD_BANK_W-1:0] bank;
  } strobe_t;

endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int NB = SD_BANKS,
  parameter int BW = SD_BANK_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          rasN,
  input  logic          casN,
  input  logic          weN,
  input  logic [BW-1:0] ba,
  input  logic          a10,
  input  logic [2*NB-1:0] bankSt,
  input  logic [NB-1:0] bankAp,
  output strobe_t       stb,
  output cmd_e          cmdQ,
  output logic          legalQ,
  output logic          illegalQ,
  output logic [BW-1:0] bankQ,
  output logic          openQ,
  output logic          burstQ,
  output logic          stopQ,
  output logic          preQ,
  output logic          refQ,
  output logic          modeQ
);

  cmd_e  cmd;
  bank_e stArr [NB];
  bank_e tgtSt;
  logic  tgtAp;
  logic  allIdle;
  logic  anyBurst;
  logic  legal;
  logic  stopNow;
  logic  refNow;

  for (genvar g = 0; g < NB; g++) begin : gUnpack
    assign stArr[g] = bank_e'(bankSt[2*g +: 2]);
  end

  assign tgtSt   = stArr[ba];
  assign tgtAp   = bankAp[ba];
  assign allIdle = (bankSt == '0);

  always_comb begin
    anyBurst = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (stArr[i] == BK_RD || stArr[i] == BK_WR) anyBurst = 1'b1;
    end
  end

  // pin decode
  always_comb begin
    if (csN) begin
      cmd = CMD_DESEL;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_TERM;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

  // legality against the addressed bank and strobe generation
  always_comb begin
    stb         = '0;
    stb.bank    = ba;
    stb.autoPre = a10;
    legal       = 1'b0;
    stopNow     = 1'b0;
    refNow      = 1'b0;
    case (cmd)
      CMD_DESEL, CMD_NOP: legal = 1'b1;
      CMD_TERM: begin
        legal         = (tgtSt == BK_RD) && !tgtAp;
        stb.termBurst = legal;
        stopNow       = legal;
      end
      CMD_READ: begin
        legal       = (tgtSt == BK_OPEN) || ((tgtSt == BK_RD) && !tgtAp);
        stb.startRd = legal;
        stopNow     = legal && (tgtSt == BK_RD);
      end
      CMD_WRITE: begin
        legal       = (tgtSt == BK_OPEN) || ((tgtSt == BK_WR) && !tgtAp);
        stb.startWr = legal;
        stopNow     = legal && (tgtSt == BK_WR);
      end
      CMD_ACT: begin
        legal       = (tgtSt == BK_IDLE);
        stb.openRow = legal;
      end
      CMD_PRE: begin
        legal      = 1'b1;
        stb.preAll = a10;
        stb.preOne = !a10;
        stopNow    = a10 ? anyBurst : ((tgtSt == BK_RD) || (tgtSt == BK_WR));
      end
      CMD_REF: begin
        legal  = allIdle;
        refNow = legal;
      end
      CMD_MRS: begin
        legal        = allIdle;
        stb.loadMode = legal;
      end
      default: legal = 1'b0;
    endcase
  end

  // per-cycle report, one clock after the sampling edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= CMD_DESEL;
      legalQ   <= 1'b0;
      illegalQ <= 1'b0;
      bankQ    <= '0;
      openQ    <= 1'b0;
      burstQ   <= 1'b0;
      stopQ    <= 1'b0;
      preQ     <= 1'b0;
      refQ     <= 1'b0;
      modeQ    <= 1'b0;
    end else begin
      cmdQ     <= cmd;
      legalQ   <= legal;
      illegalQ <= !legal;
      bankQ    <= ba;
      openQ    <= stb.openRow;
      burstQ   <= stb.startRd | stb.startWr;
      stopQ    <= stopNow;
      preQ     <= stb.preOne | stb.preAll;
      refQ     <= refNow;
      modeQ    <= stb.loadMode;
    end
  end

endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks
  import sdcmd_pkg::*;
#(
  parameter int NB = SD_BANKS,
  parameter int BW = SD_BANK_W,
  parameter int AW = 13,
  parameter int CW = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [AW-1:0]   addr,
  output logic [2*NB-1:0] bankSt,
  output logic [NB-1:0]   bankAp,
  output logic [NB*AW-1:0] rowOfBank,
  output logic [CW-1:0]   burstCol,
  output logic [AW-1:0]   modeReg
);

  localparam int CNTW = SD_CNT_W;

  logic [CNTW-1:0] lastBeat;

  // burst length code in mode bits [2:0] -> cycles minus one
  always_comb begin
    case (modeReg[2:0])
      3'd2:    lastBeat = CNTW'(1);
      3'd3:    lastBeat = CNTW'(3);
      default: lastBeat = CNTW'(0);
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : gBank
    localparam logic [BW-1:0] IDX = BW'(g);
    bank_e           st;
    logic            ap;
    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   row;
    logic            sel;

    assign sel = (stb.bank == IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st  <= BK_IDLE;
        ap  <= 1'b0;
        cnt <= '0;
        row <= '0;
      end else begin
        if (st == BK_RD || st == BK_WR) begin
          if (cnt == '0) begin
            st <= ap ? BK_IDLE : BK_OPEN;
            ap <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (sel && stb.openRow) begin
          st  <= BK_OPEN;
          row <= addr;
        end
        if (sel && (stb.startRd || stb.startWr)) begin
          st  <= stb.startRd ? BK_RD : BK_WR;
          cnt <= lastBeat;
          ap  <= stb.autoPre;
        end
        if (sel && stb.termBurst) begin
          st <= BK_OPEN;
          ap <= 1'b0;
        end
        if ((sel && stb.preOne) || stb.preAll) begin
          st <= BK_IDLE;
          ap <= 1'b0;
        end
      end
    end

    assign bankSt[2*g +: 2]     = st;
    assign bankAp[g]            = ap;
    assign rowOfBank[AW*g +: AW] = row;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstCol <= '0;
      modeReg  <= '0;
    end else begin
      if (stb.startRd || stb.startWr) burstCol <= addr[CW-1:0];
      if (stb.loadMode) modeReg <= addr;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int AW = 13,
  parameter int CW = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     rasN,
  input  logic                     casN,
  input  logic                     weN,
  input  logic [SD_BANK_W-1:0]     ba,
  input  logic [AW-1:0]            addr,
  output logic [3:0]               cmdCode,
  output logic                     cmdLegal,
  output logic                     illegalPulse,
  output logic [SD_BANK_W-1:0]     cmdBank,
  output logic                     actOpen,
  output logic                     actBurst,
  output logic                     actStop,
  output logic                     actPrecharge,
  output logic                     actRefresh,
  output logic                     actModeLoad,
  output logic [2*SD_BANKS-1:0]    bankStates,
  output logic [SD_BANKS-1:0]      autoPreFlags,
  output logic [SD_BANKS*AW-1:0]   rowOfBank,
  output logic [CW-1:0]            burstCol,
  output logic [AW-1:0]            modeReg
);

  strobe_t stb;
  cmd_e    cmdQ;

  sdcmd_ctrl #(.NB(SD_BANKS), .BW(SD_BANK_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ba       (ba),
    .a10      (addr[10]),
    .bankSt   (bankStates),
    .bankAp   (autoPreFlags),
    .stb      (stb),
    .cmdQ     (cmdQ),
    .legalQ   (cmdLegal),
    .illegalQ (illegalPulse),
    .bankQ    (cmdBank),
    .openQ    (actOpen),
    .burstQ   (actBurst),
    .stopQ    (actStop),
    .preQ     (actPrecharge),
    .refQ     (actRefresh),
    .modeQ    (actModeLoad)
  );

  sdcmd_banks #(.NB(SD_BANKS), .BW(SD_BANK_W), .AW(AW), .CW(CW)) uBanks (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addr      (addr),
    .bankSt    (bankStates),
    .bankAp    (autoPreFlags),
    .rowOfBank (rowOfBank),
    .burstCol  (burstCol),
    .modeReg   (modeReg)
  );

  assign cmdCode = cmdQ;

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdLegal,
  input logic          illegalPulse,
  input logic [BW-1:0] cmdBank,
  input logic          actOpen,
  input logic          actBurst,
  input logic          actStop,
  input logic          actPrecharge,
  input logic          actRefresh,
  input logic          actModeLoad,
  input logic [2*NB-1:0] bankStates,
  input logic [AW-1:0] modeReg
);

  logic [2*NB-1:0] prevSt;

  always_ff @(posedge clk) begin
    if (!rstN) prevSt <= '0;
    else       prevSt <= bankStates;
  end

  function automatic logic [1:0] stOf(input logic [2*NB-1:0] v, input logic [BW-1:0] b);
    return v[{b, 1'b0} +: 2];
  endfunction

  // R3: a row opens only from idle and leaves the bank open
  a_r3_open_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    actOpen |-> (stOf(prevSt, cmdBank) == 2'd0 && stOf(bankStates, cmdBank) == 2'd1));

  // R4: a started burst puts its bank in a burst state
  a_r4_burst_state: assert property (@(posedge clk) disable iff (!rstN)
    actBurst |-> stOf(bankStates, cmdBank)[1]);

  // R8: after a precharge the addressed bank is idle
  a_r8_pre_idles: assert property (@(posedge clk) disable iff (!rstN)
    actPrecharge |-> stOf(bankStates, cmdBank) == 2'd0);

  // R9: refresh only with every bank idle
  a_r9_refresh_idle: assert property (@(posedge clk) disable iff (!rstN)
    actRefresh |-> (prevSt == '0 && bankStates == '0));

  // R10: the mode value moves only on an accepted load
  a_r10_mode_only_load: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeReg) |-> actModeLoad);

  // R11: an illegal command reports no action
  a_r11_illegal_silent: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> (!cmdLegal && !actOpen && !actBurst && !actStop &&
                      !actPrecharge && !actRefresh && !actModeLoad));

endmodule

bind sdram_cmd_tracker sdcmd_checker #(.NB(4), .BW(2), .AW(13)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdLegal     (cmdLegal),
  .illegalPulse (illegalPulse),
  .cmdBank      (cmdBank),
  .actOpen      (actOpen),
  .actBurst     (actBurst),
  .actStop      (actStop),
  .actPrecharge (actPrecharge),
  .actRefresh   (actRefresh),
  .actModeLoad  (actModeLoad),
  .bankStates   (bankStates),
  .modeReg      (modeReg)
);

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  cmdCode;
  logic        cmdLegal, illegalPulse;
  logic [1:0]  cmdBank;
  logic        actOpen, actBurst, actStop, actPrecharge, actRefresh, actModeLoad;
  logic [7:0]  bankStates;
  logic [3:0]  autoPreFlags;
  logic [51:0] rowOfBank;
  logic [9:0]  burstCol;
  logic [12:0] modeReg;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u0 (.*);

  // pins {csN,rasN,casN,weN}
  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_TRM = 4'b0110,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_ACT = 4'b0011,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;
  // actions {open,burst,stop,pre,ref,mode}
  localparam logic [5:0] A_0 = 6'b000000, A_OPEN = 6'b100000, A_BURST = 6'b010000,
                         A_STOP = 6'b001000, A_PRE = 6'b000100, A_REF = 6'b000010,
                         A_MODE = 6'b000001;

  typedef struct {
    logic [3:0]  code;
    logic        legal;
    logic [1:0]  bank;
    logic [5:0]  acts;
    logic [7:0]  st;
    logic [12:0] mode;
    logic [51:0] rows;
    logic [9:0]  col;
    string       req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [12:0] mMode = '0;
  logic [12:0] mRow[4] = '{default: '0};
  logic [9:0]  mCol = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] pins, input logic [1:0] b, input logic [12:0] a,
                       input logic [3:0] code, input logic legal, input logic [5:0] acts,
                       input logic [7:0] st, input string req);
    exp_t e;
    @(negedge clk);
    {csN, rasN, casN, weN} = pins;
    ba = b;
    addr = a;
    e.code = code; e.legal = legal; e.bank = b; e.acts = acts; e.st = st;
    e.mode = mMode; e.rows = {mRow[3], mRow[2], mRow[1], mRow[0]}; e.col = mCol;
    e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares the report of the command sampled at this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(cmdCode == e.code, e.req, "cmdCode", 64'(cmdCode), 64'(e.code));
        chk(cmdLegal == e.legal && illegalPulse == !e.legal, e.req, "legal",
            64'({cmdLegal, illegalPulse}), 64'({e.legal, !e.legal}));
        if (!e.legal) chk(cmdBank == e.bank, e.req, "cmdBank", 64'(cmdBank), 64'(e.bank));
        chk({actOpen, actBurst, actStop, actPrecharge, actRefresh, actModeLoad} == e.acts,
            e.req, "actions",
            64'({actOpen, actBurst, actStop, actPrecharge, actRefresh, actModeLoad}), 64'(e.acts));
        chk(bankStates == e.st, e.req, "bankStates", 64'(bankStates), 64'(e.st));
        chk(modeReg == e.mode, e.req, "modeReg", 64'(modeReg), 64'(e.mode));
        chk(rowOfBank == e.rows, e.req, "rowOfBank", 64'(rowOfBank), 64'(e.rows));
        chk(burstCol == e.col, e.req, "burstCol", 64'(burstCol), 64'(e.col));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(bankStates == 8'h00 && modeReg == 13'h0 && rowOfBank == '0 && burstCol == '0,
        "R12", "reset state", 64'({bankStates, modeReg}), 64'(0));
    chk(cmdCode == 4'd0 && !cmdLegal && !actOpen && !actBurst && !actStop &&
        !actPrecharge && !actRefresh && !actModeLoad, "R12", "reset report",
        64'({cmdCode, cmdLegal}), 64'(0));
    rstN = 1'b1;

    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0, 8'b00000000, "R1 R2 nop");
    issue(P_DES, 2'd0, 13'h0,   4'd0, 1'b1, A_0, 8'b00000000, "R1 R2 deselect");
    issue(P_RD,  2'd0, 13'h005, 4'd3, 1'b0, A_0, 8'b00000000, "R11 read idle");
    issue(P_TRM, 2'd0, 13'h0,   4'd2, 1'b0, A_0, 8'b00000000, "R7 term idle");
    mMode = 13'h003;
    issue(P_MRS, 2'd0, 13'h003, 4'd8, 1'b1, A_MODE, 8'b00000000, "R10 mode load");
    mRow[0] = 13'h1AB;
    issue(P_ACT, 2'd0, 13'h1AB, 4'd5, 1'b1, A_OPEN, 8'b00000001, "R3 activate");
    issue(P_ACT, 2'd0, 13'h0CC, 4'd5, 1'b0, A_0,    8'b00000001, "R3 activate open bank");
    issue(P_REF, 2'd1, 13'h0,   4'd7, 1'b0, A_0,    8'b00000001, "R9 refresh not idle");
    issue(P_MRS, 2'd0, 13'h002, 4'd8, 1'b0, A_0,    8'b00000001, "R10 mode not idle");
    mCol = 10'h005;
    issue(P_RD,  2'd0, 13'h005, 4'd3, 1'b1, A_BURST, 8'b00000010, "R4 read start");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0, 8'b00000010, "R4 burst 2");
    issue(P_DES, 2'd0, 13'h0,   4'd0, 1'b1, A_0, 8'b00000010, "R2 burst 3");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0, 8'b00000010, "R4 burst 4");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0, 8'b00000001, "R4 burst end");
    mCol = 10'h007;
    issue(P_RD,  2'd0, 13'h007, 4'd3, 1'b1, A_BURST, 8'b00000010, "R4 read again");
    mCol = 10'h009;
    issue(P_RD,  2'd0, 13'h009, 4'd3, 1'b1, A_BURST | A_STOP, 8'b00000010, "R6 read interrupt");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0, 8'b00000010, "R6 restarted burst");
    issue(P_TRM, 2'd0, 13'h0,   4'd2, 1'b1, A_STOP, 8'b00000001, "R7 terminate");
    mCol = 10'h002;
    issue(P_WR,  2'd0, 13'h402, 4'd4, 1'b1, A_BURST, 8'b00000011, "R5 write autopre");
    issue(P_TRM, 2'd0, 13'h0,   4'd2, 1'b0, A_0, 8'b00000011, "R5 R7 term write");
    issue(P_WR,  2'd0, 13'h003, 4'd4, 1'b0, A_0, 8'b00000011, "R5 write over autopre");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0, 8'b00000011, "R11 burst continues");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0, 8'b00000000, "R5 autopre idle");
    mRow[1] = 13'h055;
    issue(P_ACT, 2'd1, 13'h055, 4'd5, 1'b1, A_OPEN, 8'b00000100, "R3 open bank1");
    mRow[2] = 13'h0AA;
    issue(P_ACT, 2'd2, 13'h0AA, 4'd5, 1'b1, A_OPEN, 8'b00010100, "R3 open bank2");
    mCol = 10'h001;
    issue(P_RD,  2'd1, 13'h401, 4'd3, 1'b1, A_BURST, 8'b00011000, "R5 read autopre");
    issue(P_RD,  2'd1, 13'h002, 4'd3, 1'b0, A_0,     8'b00011000, "R5 read over autopre");
    issue(P_PRE, 2'd2, 13'h000, 4'd6, 1'b1, A_PRE,   8'b00001000, "R8 precharge one");
    issue(P_WR,  2'd2, 13'h006, 4'd4, 1'b0, A_0,     8'b00001000, "R11 write idle");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0,     8'b00000000, "R5 read autopre idle");
    mRow[3] = 13'h1FFF;
    issue(P_ACT, 2'd3, 13'h1FFF, 4'd5, 1'b1, A_OPEN, 8'b01000000, "R3 open bank3");
    mRow[0] = 13'h123;
    issue(P_ACT, 2'd0, 13'h123, 4'd5, 1'b1, A_OPEN, 8'b01000001, "R3 reopen bank0");
    mCol = 10'h004;
    issue(P_WR,  2'd3, 13'h004, 4'd4, 1'b1, A_BURST, 8'b11000001, "R4 write start");
    issue(P_RD,  2'd3, 13'h005, 4'd3, 1'b0, A_0,     8'b11000001, "R6 read in write");
    issue(P_PRE, 2'd0, 13'h400, 4'd6, 1'b1, A_PRE | A_STOP, 8'b00000000, "R8 precharge all");
    issue(P_PRE, 2'd1, 13'h000, 4'd6, 1'b1, A_PRE,   8'b00000000, "R8 precharge idle");
    issue(P_REF, 2'd0, 13'h0,   4'd7, 1'b1, A_REF,   8'b00000000, "R9 refresh");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0,     8'b00000000, "R2 quiet");
    mMode = 13'h001;
    issue(P_MRS, 2'd0, 13'h001, 4'd8, 1'b1, A_MODE,  8'b00000000, "R10 mode BL2");
    mRow[0] = 13'h011;
    issue(P_ACT, 2'd0, 13'h011, 4'd5, 1'b1, A_OPEN,  8'b00000001, "R3 open BL2");
    mCol = 10'h000;
    issue(P_RD,  2'd0, 13'h000, 4'd3, 1'b1, A_BURST, 8'b00000010, "R4 read BL2");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0,     8'b00000001, "R4 BL2 end");
    mCol = 10'h001;
    issue(P_WR,  2'd0, 13'h401, 4'd4, 1'b1, A_BURST, 8'b00000011, "R5 write BL2 autopre");
    issue(P_NOP, 2'd0, 13'h0,   4'd1, 1'b1, A_0,     8'b00000000, "R5 BL2 idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule